// File: doc/BRIEF.md
# Multi-Mode Timer/Counter

This block is a 16-bit timer/counter made of a low byte and a high byte. A small control register sets how the two bytes count. A 2-bit mode field picks one of four layouts:

- a 13-bit counter: an 8-bit high byte driven by a 5-bit prescaler in the low byte;
- a full 16-bit counter;
- an 8-bit low-byte counter that reloads from the high byte;
- two separate 8-bit counters.

The count source is set by a select bit. In timer mode the block counts a machine-cycle strobe (`tick`), which an external divider supplies. In counter mode it counts falling edges of an event pin. That pin is sampled on each `tick`, so at most one event is counted per two ticks.

A run bit and an optional gate pin together enable counting. When a counter wraps to zero, its overflow flag is set. The flag stays set until software clears it or an acknowledge strobe clears it. Software reaches the three registers through a one-cycle write port and a combinational read port. Address 0 is the low byte, address 1 the high byte and address 2 the control register.

Top module: `tc_unit`

## Requirements
- R1: After reset, the low byte, the high byte and the control register all read 0, and `ovfA` and `ovfB` are 0.
- R2: Timer mode (control bit 2 = 0) adds exactly one per `tick` while counting is enabled. In cycles without `tick` the counter bytes do not change.
- R3: Counter mode (control bit 2 = 1) adds one only on a `tick` where `evtPin` is 0 and was 1 at the previous `tick`. Pin changes between ticks are not seen, so the count rate is at most one per two ticks.
- R4: With the gate bit (control bit 3) set, counting occurs only while `gatePin` is 1. With the gate bit clear, `gatePin` has no effect.
- R5: Counting also requires the run bit (control bit 4). With it clear, ticks and events leave the counter unchanged.
- R6: Mode 0 (control bits 1:0 = 00): low-byte bits 4:0 form a prescaler. Each time it wraps from 31 to 0, the high byte adds one. Low-byte bits 7:5 are never changed by counting. `ovfA` sets when the high byte and the prescaler wrap together.
- R7: Mode 1 (bits 1:0 = 01): {high, low} counts as one 16-bit value. `ovfA` sets on the step from 0xFFFF to 0x0000.
- R8: Mode 2 (bits 1:0 = 10): only the low byte counts. On the step from 0xFF, the low byte loads the high byte's value and `ovfA` sets. The high byte is unchanged.
- R9: Mode 3 (bits 1:0 = 11): the low byte counts under the select, gate and run settings and sets `ovfA` when it wraps. The high byte counts every `tick` while the second run bit (control bit 5) is 1, ignoring select and gate, and sets `ovfB` when it wraps. Control bit 5 has no effect in the other modes.
- R10: An overflow flag rises on the same clock edge where its counter wraps to zero. It then stays 1 until it is cleared.
- R11: `ackA`/`ackB`, or writing 1 to control bit 6/7, clears `ovfA`/`ovfB`. A wrap in the same cycle wins over the clear. Control bits 6 and 7 read back the two flags.
- R12: A write to a counter byte replaces its value, and that counter does not count in the write cycle. The control register reads back bits 5:0 as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle strobe, one clock wide |
| evtPin | input | 1 | External event input for counter mode |
| gatePin | input | 1 | Gate input; enables counting when the gate bit is set |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 low, 1 high, 2 control |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address; address 3 reads 0 |
| rdData | output | 8 | Read data, combinational |
| ackA | input | 1 | Clears `ovfA` |
| ackB | input | 1 | Clears `ovfB` |
| ovfA | output | 1 | Overflow flag of the main (or low split) counter |
| ovfB | output | 1 | Overflow flag of the high split counter |

## Verification
Every count result appears one clock after the edge that carries the `tick`. The same holds for the reload in mode 2 and for a set overflow flag. A clear by acknowledge or by a control write also takes effect one edge after the strobe, and register writes are visible on reads after one edge.

The bench drives each strobe at a falling clock edge, which spans exactly one rising edge. It reads and checks outputs at the next falling edge, so each check sees the state after exactly one register update.

The edge detector needs a tick with the pin high followed by a tick with it low. Counter-mode checks therefore count ticks, not clocks, when predicting the value.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    MD_PRE13   = 2'd0,
    MD_FULL16  = 2'd1,
    MD_RELOAD8 = 2'd2,
    MD_SPLIT8  = 2'd3
  } tcMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    stepA;   // advance main / low split counter
    logic    stepB;   // advance high split counter
    tcMode_e mode;
  } tcStrobe_t;

  localparam logic [1:0] ADDR_LO  = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

endpackage

// File: rtl/tc_ctrl.sv
module tc_ctrl
  import tc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              evtPin,
  input  logic              gatePin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              ackA,
  input  logic              ackB,
  input  logic              wrapA,
  input  logic              wrapB,
  output tcStrobe_t         strb,
  output logic [BYTE_W-1:0] ctlWord,
  output logic              ovfA,
  output logic              ovfB
);

  localparam int B_SEL  = 2;
  localparam int B_GATE = 3;
  localparam int B_RUNA = 4;
  localparam int B_RUNB = 5;
  localparam int B_CLRA = 6;
  localparam int B_CLRB = 7;

  logic [1:0] modeSel;
  logic       cntSel, gateEn, runA, runB;
  logic       evtSamp, flagA, flagB;
  logic       wrCtl, wrLo, wrHi, split;
  logic       evtFall, srcA, enA, holdA, clrA, clrB;

  assign wrCtl = wrEn && (wrAddr == ADDR_W'(ADDR_CTL));
  assign wrLo  = wrEn && (wrAddr == ADDR_W'(ADDR_LO));
  assign wrHi  = wrEn && (wrAddr == ADDR_W'(ADDR_HI));
  assign split = (modeSel == 2'(MD_SPLIT8));

  // Configuration register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSel <= '0;
      cntSel  <= 1'b0;
      gateEn  <= 1'b0;
      runA    <= 1'b0;
      runB    <= 1'b0;
    end else if (wrCtl) begin
      modeSel <= wrData[1:0];
      cntSel  <= wrData[B_SEL];
      gateEn  <= wrData[B_GATE];
      runA    <= wrData[B_RUNA];
      runB    <= wrData[B_RUNB];
    end
  end

  // Event pin sampled once per machine cycle
  always_ff @(posedge clk) begin
    if (!rstN)     evtSamp <= 1'b0;
    else if (tick) evtSamp <= evtPin;
  end

  assign evtFall = tick && evtSamp && !evtPin;
  assign srcA    = cntSel ? evtFall : tick;
  assign enA     = runA && (!gateEn || gatePin);
  assign holdA   = wrLo || (wrHi && !split);

  always_comb begin
    strb.stepA = srcA && enA && !holdA;
    strb.stepB = split && tick && runB && !wrHi;
    strb.mode  = tcMode_e'(modeSel);
  end

  // Overflow flags: a wrap wins over a clear
  assign clrA = ackA || (wrCtl && wrData[B_CLRA]);
  assign clrB = ackB || (wrCtl && wrData[B_CLRB]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagA <= 1'b0;
      flagB <= 1'b0;
    end else begin
      flagA <= wrapA || (flagA && !clrA);
      flagB <= wrapB || (flagB && !clrB);
    end
  end

  assign ovfA = flagA;
  assign ovfB = flagB;

  always_comb begin
    ctlWord = '0;
    ctlWord[7:0] = {flagB, flagA, runB, runA, gateEn, cntSel, modeSel};
  end

  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepA |-> tick);                                            // R2
  AST_EDGE_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (cntSel && strb.stepA) |=> !(cntSel && strb.stepA));             // R3
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn && !gatePin) |-> !strb.stepA);                           // R4
  AST_RUN_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !runA |-> !strb.stepA);                                          // R5
  AST_SPLIT_ONLY_B: assert property (@(posedge clk) disable iff (!rstN)
    !split |-> !strb.stepB);                                         // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagA && !clrA) |=> flagA);                                     // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrA && !wrapA) |=> !flagA);                                    // R11

endmodule

// File: rtl/tc_dp.sv
module tc_dp
  import tc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcStrobe_t         strb,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] loByte,
  output logic [BYTE_W-1:0] hiByte,
  output logic              wrapA,
  output logic              wrapB
);

  localparam logic [PRE_W-1:0]  PRE_MAX  = '1;
  localparam logic [BYTE_W-1:0] BYTE_MAX = '1;

  logic             preFull, loFull, hiFull;
  logic [PRE_W-1:0] preNext;

  assign preFull = (loByte[PRE_W-1:0] == PRE_MAX);
  assign loFull  = (loByte == BYTE_MAX);
  assign hiFull  = (hiByte == BYTE_MAX);
  assign preNext = loByte[PRE_W-1:0] + PRE_W'(1);

  // Low byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loByte <= '0;
    end else if (wrLo) begin
      loByte <= wrData;
    end else if (strb.stepA) begin
      unique case (strb.mode)
        MD_PRE13:   loByte <= {loByte[BYTE_W-1:PRE_W], preNext};
        MD_RELOAD8: loByte <= loFull ? hiByte : loByte + BYTE_W'(1);
        default:    loByte <= loByte + BYTE_W'(1);
      endcase
    end
  end

  // High byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiByte <= '0;
    end else if (wrHi) begin
      hiByte <= wrData;
    end else if ((strb.stepA && strb.mode == MD_PRE13 && preFull) ||
                 (strb.stepA && strb.mode == MD_FULL16 && loFull) ||
                 strb.stepB) begin
      hiByte <= hiByte + BYTE_W'(1);
    end
  end

  always_comb begin
    unique case (strb.mode)
      MD_PRE13:  wrapA = strb.stepA && preFull && hiFull;
      MD_FULL16: wrapA = strb.stepA && loFull && hiFull;
      default:   wrapA = strb.stepA && loFull;
    endcase
    wrapB = strb.stepB && hiFull;
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.stepA && !strb.stepB && !wrLo && !wrHi)
      |=> ($stable(loByte) && $stable(hiByte)));                     // R2
  AST_PRE_TOP_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepA && strb.mode == MD_PRE13 && !wrLo)
      |=> $stable(loByte[BYTE_W-1:PRE_W]));                          // R6
  AST_FULL_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepA && strb.mode == MD_FULL16 && loFull && !wrHi)
      |=> (hiByte == BYTE_W'($past(hiByte) + 1'b1)));                // R7
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepA && strb.mode == MD_RELOAD8 && loFull && !wrLo)
      |=> (loByte == $past(hiByte)));                                // R8

endmodule

// File: rtl/tc_unit.sv
module tc_unit
  import tc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              evtPin,
  input  logic              gatePin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  input  logic              ackA,
  input  logic              ackB,
  output logic              ovfA,
  output logic              ovfB
);

  tcStrobe_t         strb;
  logic [BYTE_W-1:0] loByte, hiByte, ctlWord;
  logic              wrapA, wrapB, wrLo, wrHi;

  assign wrLo = wrEn && (wrAddr == ADDR_W'(ADDR_LO));
  assign wrHi = wrEn && (wrAddr == ADDR_W'(ADDR_HI));

  tc_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .evtPin(evtPin), .gatePin(gatePin),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .ackA(ackA), .ackB(ackB),
    .wrapA(wrapA), .wrapB(wrapB), .strb(strb), .ctlWord(ctlWord),
    .ovfA(ovfA), .ovfB(ovfB)
  );

  tc_dp #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrLo(wrLo), .wrHi(wrHi),
    .wrData(wrData), .loByte(loByte), .hiByte(hiByte),
    .wrapA(wrapA), .wrapB(wrapB)
  );

  always_comb begin
    if (rdAddr == ADDR_W'(ADDR_LO))       rdData = loByte;
    else if (rdAddr == ADDR_W'(ADDR_HI))  rdData = hiByte;
    else if (rdAddr == ADDR_W'(ADDR_CTL)) rdData = ctlWord;
    else                                  rdData = '0;
  end

endmodule

// File: tb/tb_tc_unit.sv
module tb_tc_unit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN, tick, evtPin, gatePin, wrEn, ackA, ackB;
  logic [1:0] wrAddr, rdAddr;
  logic [7:0] wrData, rdData;
  logic       ovfA, ovfB;
  int         nRun = 0;
  int         nFail = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tc_unit dut (
    .clk(clk), .rstN(rstN), .tick(tick), .evtPin(evtPin), .gatePin(gatePin),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .ackA(ackA), .ackB(ackB), .ovfA(ovfA), .ovfB(ovfB)
  );

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rdAddr = a;
    #1 v = rdData;
  endtask

  task automatic chkCount(input string req, input int expLo, input int expHi);
    logic [7:0] v;
    rd(2'd0, v); chk({req, " low"}, v, expLo);
    rd(2'd1, v); chk({req, " high"}, v, expHi);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Write config and clear both flags
  task automatic cfg(input logic [7:0] d);
    wr(2'd2, d | 8'hC0);
  endtask

  task automatic load(input logic [7:0] lo, input logic [7:0] hi);
    wr(2'd0, lo);
    wr(2'd1, hi);
  endtask

  task automatic pulseTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulseTick();
  endtask

  task automatic tReset();
    logic [7:0] v;
    chkCount("R1 reset", 0, 0);
    rd(2'd2, v); chk("R1 reset ctl", v, 0);
    chk("R1 reset ovfA", ovfA, 0);
    chk("R1 reset ovfB", ovfB, 0);
  endtask

  task automatic tFull16();
    cfg(8'h11); load(8'hFD, 8'hFF);
    ticks(2);
    chkCount("R7 16-bit count", 8'hFF, 8'hFF);
    chk("R10 no flag before wrap", ovfA, 0);
    pulseTick();
    chkCount("R7 16-bit wrap", 0, 0);
    chk("R10 flag on wrap", ovfA, 1);
    ticks(2);
    chk("R10 flag stays set", ovfA, 1);
    chkCount("R2 one per tick", 2, 0);
    load(8'hFF, 8'h12); pulseTick();
    chkCount("R7 carry into high", 0, 8'h13);
  endtask

  task automatic tIdle();
    cfg(8'h11); load(8'h20, 8'h00);
    repeat (6) @(negedge clk);
    chkCount("R2 no tick no change", 8'h20, 0);
    cfg(8'h01); ticks(4);
    chkCount("R5 run off holds", 8'h20, 0);
  endtask

  task automatic tGate();
    cfg(8'h19); load(0, 0);
    gatePin = 1'b0; ticks(3);
    chkCount("R4 gate low blocks", 0, 0);
    gatePin = 1'b1; ticks(2);
    chkCount("R4 gate high runs", 2, 0);
    cfg(8'h11); gatePin = 1'b0; ticks(3);
    chkCount("R4 gate bit clear ignores pin", 5, 0);
  endtask

  task automatic tCounter();
    cfg(8'h15); load(0, 0);
    evtPin = 1'b1; pulseTick();
    chkCount("R3 rise not counted", 0, 0);
    evtPin = 1'b0; pulseTick();
    chkCount("R3 fall counted", 1, 0);
    pulseTick();
    chkCount("R3 steady low not counted", 1, 0);
    evtPin = 1'b1; @(negedge clk);
    evtPin = 1'b0; @(negedge clk);
    evtPin = 1'b1; pulseTick();
    chkCount("R3 pulse between ticks unseen", 1, 0);
    for (int i = 0; i < 8; i++) begin
      evtPin = (i % 2 == 0) ? 1'b0 : 1'b1;
      pulseTick();
    end
    chkCount("R3 max rate one per two ticks", 5, 0);
    evtPin = 1'b0;
  endtask

  task automatic tPre13();
    cfg(8'h10); load(8'hFE, 8'h05);
    pulseTick();
    chkCount("R6 prescaler step", 8'hFF, 8'h05);
    pulseTick();
    chkCount("R6 prescaler carry, top bits kept", 8'hE0, 8'h06);
    chk("R6 no flag", ovfA, 0);
    load(8'h1F, 8'hFF); pulseTick();
    chkCount("R6 13-bit wrap", 0, 0);
    chk("R6 flag on 13-bit wrap", ovfA, 1);
  endtask

  task automatic tReload();
    cfg(8'h12); load(8'hFE, 8'hC8);
    pulseTick();
    chkCount("R8 count", 8'hFF, 8'hC8);
    chk("R8 no flag yet", ovfA, 0);
    pulseTick();
    chkCount("R8 reload from high", 8'hC8, 8'hC8);
    chk("R8 flag on reload", ovfA, 1);
    pulseTick();
    chkCount("R8 count after reload", 8'hC9, 8'hC8);
  endtask

  task automatic tSplit();
    logic [7:0] v;
    cfg(8'h33); load(8'hFF, 8'hFE);
    rd(2'd2, v); chk("R12 ctl readback", v, 8'h33);
    pulseTick();
    chkCount("R9 split step", 0, 8'hFF);
    chk("R9 low flag", ovfA, 1);
    chk("R9 high flag not yet", ovfB, 0);
    pulseTick();
    chkCount("R9 split high wrap", 1, 0);
    chk("R9 high flag", ovfB, 1);
    rd(2'd2, v); chk("R11 flags read back", v, 8'hF3);
    cfg(8'h2F); load(8'h40, 8'h10); gatePin = 1'b0;
    ticks(3);
    chkCount("R9 high ignores gate and select", 8'h40, 8'h13);
    cfg(8'h31); load(0, 0); ticks(2);
    chkCount("R9 second run bit no effect in mode 1", 2, 0);
  endtask

  task automatic tFlags();
    cfg(8'h33); load(8'hFF, 8'hFF);
    pulseTick();
    chk("R11 setup ovfA", ovfA, 1);
    chk("R11 setup ovfB", ovfB, 1);
    ackA = 1'b1; @(negedge clk); ackA = 1'b0;
    chk("R11 ackA clears", ovfA, 0);
    chk("R11 ackA leaves ovfB", ovfB, 1);
    ackB = 1'b1; @(negedge clk); ackB = 1'b0;
    chk("R11 ackB clears", ovfB, 0);
    cfg(8'h11); load(8'hFF, 8'hFF);
    pulseTick();
    wr(2'd2, 8'h51);
    chk("R11 write-one clear", ovfA, 0);
    load(8'hFF, 8'hFF);
    tick = 1'b1; ackA = 1'b1;
    @(negedge clk);
    tick = 1'b0; ackA = 1'b0;
    chk("R11 wrap wins over clear", ovfA, 1);
  endtask

  task automatic tWrite();
    cfg(8'h11); load(8'h10, 8'h00);
    tick = 1'b1;
    wr(2'd0, 8'h40);
    tick = 1'b0;
    chkCount("R12 write wins over count", 8'h40, 0);
    pulseTick();
    chkCount("R12 counts after write", 8'h41, 0);
  endtask

  initial begin
    rstN = 1'b0; tick = 1'b0; evtPin = 1'b0; gatePin = 1'b0;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    ackA = 1'b0; ackB = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFull16();
    tIdle();
    tGate();
    tCounter();
    tPre13();
    tReload();
    tSplit();
    tFlags();
    tWrite();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule